// File: doc/BRIEF.md
# Paged Program Address Sequencer

This block owns the program counter of a small 8-bit controller whose program memory holds 2048 words of 14 bits. Each clock it takes the decoded flow-control request of the instruction now executing and forms the next 11-bit fetch address. The candidate addresses are the incremented address, a short jump or short call, a long jump or long call, a computed write from the ALU, and a return. Short transfers and computed writes carry fewer than 11 address bits. Their upper bits come from a two-bit page field held in the status register, so the page picks one of four 512-word quarters of the program space.

Calls save the address after the call on a two-entry hardware return stack. Returns reload the whole address from the top of that stack. A return-with-literal also hands its 8-bit immediate to the working register one cycle later. A skip request marks the next instruction as squashed. In that cycle the address still advances by one, and the control inputs and any skip request are ignored.

Memory, instruction decode and the ALU sit outside the block. Their results arrive on plain input ports.

Top module: `prog_addr_gen`

## Requirements
- R1: A synchronous active-high reset sets fetch_addr to 7FFh, squash to 0, lit_vld to 0 and both return-stack entries to 000h.
- R2: With op code 0 (sequential), fetch_addr becomes fetch_addr+1 on the next edge and wraps from 7FFh to 000h.
- R3: Op code 3 (long jump) loads all 11 bits of ins_addr into fetch_addr.
- R4: Op code 1 (short jump) loads {page_sel, ins_addr[8:0]}. Page values 0 to 3 therefore reach 000h-1FFh, 200h-3FFh, 400h-5FFh and 600h-7FFh.
- R5: Op code 2 (short call) loads {page_sel, 0, ins_addr[7:0]} and pushes fetch_addr+1.
- R6: Op code 4 (long call) loads ins_addr and pushes fetch_addr+1.
- R7: Op code 5 (PC write) loads {page_sel, 0, alu_res}.
- R8: Op code 6 (return) loads the top stack entry into fetch_addr and pops it, so the stack behaves last-in first-out.
- R9: Op code 7 (return with literal) acts like op 6. In the next cycle lit_vld is 1 for exactly one cycle and lit_out equals the ins_lit of the return.
- R10: skip_req in a cycle where squash is 0 makes squash 1 in the next cycle. The current op still takes effect.
- R11: In a cycle where squash is 1, ctl_op and skip_req are ignored. fetch_addr increments, the stack is untouched, lit_vld stays 0 and squash returns to 0.
- R12: A push onto a full stack drops the oldest entry.
- R13: A pop of an empty stack returns the last entry that remained. No error is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_op | input | 3 | Decoded flow-control op code (0 to 7) |
| skip_req | input | 1 | Squash the following instruction |
| ins_addr | input | 11 | Address field of the instruction word |
| ins_lit | input | 8 | Immediate of a return-with-literal |
| page_sel | input | 2 | Page bits from the status register |
| alu_res | input | 8 | ALU result for a PC write |
| fetch_addr | output | 11 | Current program fetch address |
| squash | output | 1 | Instruction in this cycle is a no-op |
| lit_vld | output | 1 | lit_out holds a literal for the working register |
| lit_out | output | 8 | Literal from the last return-with-literal |

## Verification
A skip request and a flow-control op can coincide in one squashed cycle. The instruction after a skip may be a call, a return, a return-with-literal or a second skip. All of these must then vanish: the PC only increments, no stack entry moves and no literal appears.

Directed sequences place each of these ops right after a skip, and follow a squashed call with a real return to show that nothing was pushed. Random op streams with frequent skips then run against a behavioural queue-based model, which compares address, squash and literal outputs on every clock.

// File: rtl/pag_pkg.sv
package pag_pkg;

    typedef enum logic [2:0] {
        OP_SEQ   = 3'd0,
        OP_SJMP  = 3'd1,
        OP_SCALL = 3'd2,
        OP_LJMP  = 3'd3,
        OP_LCALL = 3'd4,
        OP_PCWR  = 3'd5,
        OP_RET   = 3'd6,
        OP_RETL  = 3'd7
    } pag_op_e;

    typedef struct packed {
        logic push;
        logic pop;
        logic lit_ld;
    } pag_stk_ctl_t;

    function automatic pag_stk_ctl_t pag_decode(input pag_op_e op);
        pag_stk_ctl_t c;
        c.push   = (op == OP_SCALL) || (op == OP_LCALL);
        c.pop    = (op == OP_RET)   || (op == OP_RETL);
        c.lit_ld = (op == OP_RETL);
        return c;
    endfunction

endpackage

// File: rtl/pag_slot.sv
module pag_slot
    import pag_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pag_op_e op_in,
    input  logic    skip_req,
    output pag_op_e op_eff,
    output logic    squash
);
    always_ff @(posedge clk) begin
        if (rst) squash <= 1'b0;
        else     squash <= !squash && skip_req;
    end

    assign op_eff = squash ? OP_SEQ : op_in;
endmodule

// File: rtl/pag_next.sv
module pag_next
    import pag_pkg::*;
#(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  pag_op_e          op,
    input  logic [AW-1:0]    pc,
    input  logic [AW-1:0]    addr,
    input  logic [AW-DW-2:0] page,
    input  logic [DW-1:0]    alu,
    input  logic [AW-1:0]    stk_top,
    output logic [AW-1:0]    pc_inc,
    output logic [AW-1:0]    pc_nxt
);
    logic [DW-1:0] low_byte;

    assign pc_inc   = pc + 1'b1;
    assign low_byte = (op == OP_PCWR) ? alu : addr[DW-1:0];

    always_comb begin
        unique case (op)
            OP_SEQ:             pc_nxt = pc_inc;
            OP_SJMP:            pc_nxt = {page, addr[DW:0]};
            OP_SCALL, OP_PCWR:  pc_nxt = {page, 1'b0, low_byte};
            OP_LJMP, OP_LCALL:  pc_nxt = addr;
            default:            pc_nxt = stk_top;
        endcase
    end
endmodule

// File: rtl/pag_stack.sv
module pag_stack #(
    parameter int AW    = 11,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_val,
    output logic [AW-1:0] top
);
    logic [AW-1:0] entry [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [AW-1:0] from_above;
        logic [AW-1:0] from_below;

        if (i == 0) begin : g_head
            assign from_above = push_val;
        end else begin : g_body
            assign from_above = entry[i-1];
        end

        if (i == DEPTH - 1) begin : g_tail
            assign from_below = entry[i];
        end else begin : g_mid
            assign from_below = entry[i+1];
        end

        always_ff @(posedge clk) begin
            if (rst)       entry[i] <= '0;
            else if (push) entry[i] <= from_above;
            else if (pop)  entry[i] <= from_below;
        end
    end

    assign top = entry[0];
endmodule

// File: rtl/prog_addr_gen.sv
module prog_addr_gen
    import pag_pkg::*;
#(
    parameter int AW        = 11,
    parameter int DW        = 8,
    parameter int STK_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       ctl_op,
    input  logic             skip_req,
    input  logic [AW-1:0]    ins_addr,
    input  logic [DW-1:0]    ins_lit,
    input  logic [AW-DW-2:0] page_sel,
    input  logic [DW-1:0]    alu_res,
    output logic [AW-1:0]    fetch_addr,
    output logic             squash,
    output logic             lit_vld,
    output logic [DW-1:0]    lit_out
);
    pag_op_e      op_eff;
    pag_stk_ctl_t sctl;
    logic [AW-1:0] pc_inc, pc_nxt, stk_top;

    pag_slot u_slot (
        .clk      (clk),
        .rst      (rst),
        .op_in    (pag_op_e'(ctl_op)),
        .skip_req (skip_req),
        .op_eff   (op_eff),
        .squash   (squash)
    );

    assign sctl = pag_decode(op_eff);

    pag_next #(.AW(AW), .DW(DW)) u_next (
        .op      (op_eff),
        .pc      (fetch_addr),
        .addr    (ins_addr),
        .page    (page_sel),
        .alu     (alu_res),
        .stk_top (stk_top),
        .pc_inc  (pc_inc),
        .pc_nxt  (pc_nxt)
    );

    pag_stack #(.AW(AW), .DEPTH(STK_DEPTH)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (sctl.push),
        .pop      (sctl.pop),
        .push_val (pc_inc),
        .top      (stk_top)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_addr <= '1;
            lit_vld    <= 1'b0;
            lit_out    <= '0;
        end else begin
            fetch_addr <= pc_nxt;
            lit_vld    <= sctl.lit_ld;
            if (sctl.lit_ld) lit_out <= ins_lit;
        end
    end
endmodule

// File: rtl/pag_chk.sv
module pag_chk #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       ctl_op,
    input logic             skip_req,
    input logic [AW-1:0]    ins_addr,
    input logic [DW-1:0]    ins_lit,
    input logic [AW-DW-2:0] page_sel,
    input logic [DW-1:0]    alu_res,
    input logic [AW-1:0]    fetch_addr,
    input logic             squash,
    input logic             lit_vld,
    input logic [DW-1:0]    lit_out
);
    // R1
    reset_vec_chk: assert property (@(posedge clk)
        rst |=> (fetch_addr == '1 && !squash && !lit_vld));

    // R2
    seq_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (!squash && ctl_op == 3'd0) |=> fetch_addr == AW'($past(fetch_addr) + 1'b1));

    // R3
    long_jmp_chk: assert property (@(posedge clk) disable iff (rst)
        (!squash && ctl_op == 3'd3) |=> fetch_addr == $past(ins_addr));

    // R4
    short_jmp_chk: assert property (@(posedge clk) disable iff (rst)
        (!squash && ctl_op == 3'd1) |=>
            fetch_addr == {$past(page_sel), $past(ins_addr[DW:0])});

    // R7
    pc_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!squash && ctl_op == 3'd5) |=>
            fetch_addr == {$past(page_sel), 1'b0, $past(alu_res)});

    // R8
    call_ret_chk: assert property (@(posedge clk) disable iff (rst)
        (!squash && ctl_op == 3'd4) ##1 (!squash && ctl_op == 3'd6) |=>
            fetch_addr == AW'($past(fetch_addr, 2) + 1'b1));

    // R9
    lit_out_chk: assert property (@(posedge clk) disable iff (rst)
        (!squash && ctl_op == 3'd7) |=> (lit_vld && lit_out == $past(ins_lit)));

    // R10
    skip_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!squash && skip_req) |=> squash);

    // R11
    squash_ign_chk: assert property (@(posedge clk) disable iff (rst)
        squash |=> (!squash && !lit_vld && fetch_addr == AW'($past(fetch_addr) + 1'b1)));
endmodule

bind prog_addr_gen pag_chk #(.AW(AW), .DW(DW)) u_pag_chk (
    .clk        (clk),
    .rst        (rst),
    .ctl_op     (ctl_op),
    .skip_req   (skip_req),
    .ins_addr   (ins_addr),
    .ins_lit    (ins_lit),
    .page_sel   (page_sel),
    .alu_res    (alu_res),
    .fetch_addr (fetch_addr),
    .squash     (squash),
    .lit_vld    (lit_vld),
    .lit_out    (lit_out)
);

// File: tb/test_prog_addr_gen.sv
module test_prog_addr_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  ctl_op = '0;
    logic        skip_req = 1'b0;
    logic [10:0] ins_addr = '0;
    logic [7:0]  ins_lit = '0;
    logic [1:0]  page_sel = '0;
    logic [7:0]  alu_res = '0;
    logic [10:0] fetch_addr;
    logic        squash, lit_vld;
    logic [7:0]  lit_out;

    int errors = 0;
    int checks = 0;

    // behavioural reference state
    int unsigned m_pc;
    bit          m_sq, m_lv;
    int unsigned m_lo;
    int unsigned m_stk[$];

    always #2 clk = ~clk;

    prog_addr_gen i_prog_addr_gen (
        .clk(clk), .rst(rst), .ctl_op(ctl_op), .skip_req(skip_req),
        .ins_addr(ins_addr), .ins_lit(ins_lit), .page_sel(page_sel),
        .alu_res(alu_res), .fetch_addr(fetch_addr), .squash(squash),
        .lit_vld(lit_vld), .lit_out(lit_out)
    );

    task automatic chk(input string tag, input string what,
                       input int unsigned act, input int unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "fetch_addr", fetch_addr, m_pc);
        chk(tag, "squash", squash, m_sq);
        chk(tag, "lit_vld", lit_vld, m_lv);
        if (m_lv) chk(tag, "lit_out", lit_out, m_lo);
    endtask

    task automatic do_reset();
        rst = 1'b1; ctl_op = 3'd0; skip_req = 1'b0;
        @(posedge clk);
        m_pc = 'h7FF; m_sq = 0; m_lv = 0; m_lo = 0;
        m_stk = '{0, 0};
        @(negedge clk);
        compare("R1");
        rst = 1'b0;
    endtask

    task automatic step(input int op, input bit skp, input int addr, input int alu,
                        input int lit, input int page, input string tag);
        int eff;
        int unsigned nxt;
        ctl_op = 3'(op); skip_req = skp; ins_addr = 11'(addr);
        alu_res = 8'(alu); ins_lit = 8'(lit); page_sel = 2'(page);
        @(posedge clk);
        eff = m_sq ? 0 : op;
        case (eff)
            1: nxt = (page << 9) | (addr & 'h1FF);
            2: nxt = (page << 9) | (addr & 'hFF);
            3, 4: nxt = addr & 'h7FF;
            5: nxt = (page << 9) | (alu & 'hFF);
            6, 7: begin
                nxt = m_stk[0];
                if (m_stk.size() > 1) void'(m_stk.pop_front());
            end
            default: nxt = (m_pc + 1) & 'h7FF;
        endcase
        if (eff == 2 || eff == 4) begin
            m_stk.push_front((m_pc + 1) & 'h7FF);
            if (m_stk.size() > 2) void'(m_stk.pop_back());
        end
        m_lv = (eff == 7);
        if (m_lv) m_lo = lit & 'hFF;
        m_sq = !m_sq && skp;
        m_pc = nxt;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        do_reset();
        // R2 sequential and wrap
        step(0, 0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, "R2");
        step(3, 0, 'h7FE, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, "R2 wrap");
        step(3, 0, 'h5A5, 0, 0, 3, "R3");
        // R4 each page
        for (int p = 0; p < 4; p++) step(1, 0, 'h7C3, 0, 0, p, "R4");
        // R5 short call then return
        step(2, 0, 'h6F4, 0, 0, 2, "R5");
        step(0, 0, 0, 0, 0, 0, "R2");
        step(6, 0, 0, 0, 0, 0, "R8");
        // R6 and R12 overflow, R13 empty pop
        step(4, 0, 'h100, 0, 0, 0, "R6");
        step(4, 0, 'h200, 0, 0, 0, "R6");
        step(4, 0, 'h300, 0, 0, 0, "R12");
        step(6, 0, 0, 0, 0, 0, "R8");
        step(6, 0, 0, 0, 0, 0, "R12");
        step(6, 0, 0, 0, 0, 0, "R13");
        step(6, 0, 0, 0, 0, 0, "R13");
        // R7
        step(5, 0, 'h1FF, 'hAB, 0, 3, "R7");
        step(5, 0, 'h1FF, 'h00, 0, 1, "R7");
        // R9
        step(4, 0, 'h0C0, 0, 0, 0, "R6");
        step(7, 0, 0, 0, 'h5A, 0, "R9");
        step(0, 0, 0, 0, 0, 0, "R9 one cycle");
        // R10 / R11
        step(0, 1, 0, 0, 0, 0, "R10");
        step(3, 1, 'h333, 0, 0, 0, "R11");
        step(0, 0, 0, 0, 0, 0, "R11");
        step(4, 0, 'h040, 0, 0, 0, "R6");
        step(3, 1, 'h400, 0, 0, 0, "R10");
        step(4, 0, 'h500, 0, 0, 0, "R11");
        step(7, 0, 0, 0, 'h77, 0, "R11");
        step(6, 0, 0, 0, 0, 0, "R11");
        step(0, 1, 0, 0, 0, 0, "R10");
        step(7, 0, 0, 0, 'h99, 0, "R11");
        // mixed stream
        for (int k = 0; k < 400; k++)
            step(int'($urandom_range(0, 7)), ($urandom_range(0, 3) == 0),
                 int'($urandom_range(0, 'h7FF)), int'($urandom_range(0, 255)),
                 int'($urandom_range(0, 255)), int'($urandom_range(0, 3)), "mix");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule